// File: doc/BRIEF.md
# SAR ADC conversion sequencer

This block is the digital half of a successive-approximation converter. It picks one of twelve analog inputs, drives a trial code to an external ladder DAC, reads back a single comparator bit, and resolves the input one bit at a time starting from the most significant bit. Software starts a conversion by setting a start bit. In capture-trigger configuration, the conversion waits for a timer event that arrives while that bit is already set.

Each conversion takes a fixed number of cycles, chosen by the resolution (8 or 10 bits) and by whether the sample-and-hold timing is in use. The cycles before the bit trials form a sampling window. Repeat mode runs back-to-back conversions on the same channel, and it always runs them at 8-bit resolution. The finished code goes to a right-aligned result register.

Top module: `adc_sar_sequencer`

## Requirements
- R1: The 4-bit `chan_sel` value (0 to 11) is captured when a conversion launches. It appears on `chan_out` and stays there for the whole conversion, including repeat restarts.
- R2: With `capture_mode` low, a `start_set` pulse sets `start_bit` on the next edge. The conversion launches one edge later, and `busy` goes high.
- R3: With `capture_mode` high, a conversion launches only on an edge where `timer_evt` is high and `start_bit` is already 1. A `timer_evt` while `start_bit` is 0 has no effect.
- R4: With `res10` high and repeat off, the trials cover `trial_code[9:0]`. Otherwise the 8 trials cover `trial_code[9:2]`, and `trial_code[1:0]` stays 0.
- R5: Without sample-and-hold (`hold_en` low), `busy` stays high for 49 cycles in 8-bit mode and 59 cycles in 10-bit mode. `done` rises in the cycle after the last of these.
- R6: With `hold_en` high, the same spans are 28 cycles (8-bit) and 33 cycles (10-bit).
- R7: The first L-2N-1 cycles of a conversion are the sampling window, where L is the span and N the bit count. During this window `sample` is high and `trial_code` is 0.
- R8: Each trial takes two cycles, MSB first. In the first cycle the bit under test is set. At the end of the second cycle the bit is kept if `cmp_in` is 1 (input at or above the trial level) and cleared if `cmp_in` is 0.
- R9: An input above the reference, with `cmp_in` always 1, gives 3FFh in 10-bit mode and 0FFh in 8-bit mode.
- R10: `result` is written only when a conversion ends. An 8-bit result occupies bits [7:0], and bits [9:8] read 0. `result` resets to 0.
- R11: At the end of a one-shot conversion, `start_bit` clears, `done` is high for exactly one cycle, `busy` falls, and `trial_code` returns to 0.
- R12: In repeat mode, `start_bit` stays 1. A new conversion on the same channel starts in the cycle after the last one, at 8-bit resolution even if `res10` is high, and `done` pulses at the end of each conversion.
- R13: A `start_clr` pulse during a conversion has these effects on the next edge: `busy` drops, `start_bit` clears, `trial_code` returns to 0, `result` is unchanged, and no `done` pulse appears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | ADC operating clock |
| rst | input | 1 | Synchronous active-high reset |
| start_set | input | 1 | Software write of 1 to the start bit (pulse) |
| start_clr | input | 1 | Software write of 0 to the start bit (pulse), takes priority |
| chan_sel | input | 4 | Analog input select, 0 to 11 |
| res10 | input | 1 | 1 selects 10-bit resolution |
| repeat_en | input | 1 | 1 selects repeat operation |
| hold_en | input | 1 | 1 selects sample-and-hold timing |
| capture_mode | input | 1 | 1 makes timer events the launch trigger |
| timer_evt | input | 1 | Timer capture event |
| cmp_in | input | 1 | Comparator: 1 when input is at or above the trial level |
| trial_code | output | 10 | Trial code to the DAC, MSB aligned |
| chan_out | output | 4 | Channel routed to the comparator |
| sample | output | 1 | Sampling window active |
| busy | output | 1 | Conversion in progress |
| start_bit | output | 1 | Current value of the start bit |
| done | output | 1 | One-cycle end-of-conversion pulse |
| result | output | 10 | Right-aligned conversion result |

## Verification
The assertions assume that `chan_sel` never names a channel above 11 when a launch can happen. They also assume that the comparator reacts to the current trial code within the same cycle, so that its answer is settled at the judging edge. The stimulus keeps to both assumptions. It changes inputs only on falling edges and uses channels 0 to 11 only. It models the comparator as a combinational compare of a fixed 10-bit input level against `trial_code`, and it changes that level only during a sampling window.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

  typedef struct packed {
    logic hi;    // 10-bit conversion in effect
    logic hold;  // sample-and-hold timing
    logic rep;   // repeat operation
  } conv_mode_t;

  typedef enum logic [1:0] {
    PH_IDLE,
    PH_SAMPLE,
    PH_TRIAL,
    PH_STORE
  } conv_phase_e;

  // Repeat operation only runs at the narrow resolution.
  function automatic conv_mode_t make_mode(input logic res10, input logic hold_en,
                                           input logic repeat_en);
    conv_mode_t m;
    m.hi   = res10 & ~repeat_en;
    m.hold = hold_en;
    m.rep  = repeat_en;
    return m;
  endfunction

endpackage

// File: rtl/adc_seq_trigger.sv
module adc_seq_trigger (
  input  logic clk,
  input  logic rst,
  input  logic start_set,
  input  logic start_clr,
  input  logic capture_mode,
  input  logic timer_evt,
  input  logic busy,
  input  logic oneshot_end,
  output logic start_bit,
  output logic launch
);

  always_ff @(posedge clk) begin
    if (rst)              start_bit <= 1'b0;
    else if (start_clr)   start_bit <= 1'b0;
    else if (oneshot_end) start_bit <= 1'b0;
    else if (start_set)   start_bit <= 1'b1;
  end

  always_comb begin
    launch = ~busy & start_bit & ~start_clr & (~capture_mode | timer_evt);
  end

endmodule

// File: rtl/adc_seq_timer.sv
module adc_seq_timer
  import adc_seq_pkg::*;
#(
  parameter int CNT_W = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             launch,
  input  logic             abort,
  input  logic             rearm,
  input  logic [CNT_W-1:0] span,
  input  logic [CNT_W-1:0] samp_len,
  output logic             busy,
  output logic [CNT_W-1:0] cnt,
  output logic             last,
  output conv_phase_e      phase
);

  always_comb begin
    last = busy && (cnt == span - CNT_W'(1));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy <= 1'b0;
      cnt  <= '0;
    end else if (abort) begin
      busy <= 1'b0;
      cnt  <= '0;
    end else if (launch) begin
      busy <= 1'b1;
      cnt  <= '0;
    end else if (busy) begin
      if (last) begin
        busy <= rearm;
        cnt  <= '0;
      end else begin
        cnt <= cnt + CNT_W'(1);
      end
    end
  end

  always_comb begin
    if (!busy)               phase = PH_IDLE;
    else if (cnt < samp_len) phase = PH_SAMPLE;
    else if (last)           phase = PH_STORE;
    else                     phase = PH_TRIAL;
  end

endmodule

// File: rtl/adc_seq_sar.sv
module adc_seq_sar #(
  parameter int CODE_W = 10,
  parameter int LO_W   = 8,
  parameter int CNT_W  = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clear,
  input  logic              busy,
  input  logic              hi,
  input  logic [CNT_W-1:0]  cnt,
  input  logic [CNT_W-1:0]  samp_len,
  input  logic              cmp_in,
  input  logic              store,
  output logic [CODE_W-1:0] code,
  output logic [CODE_W-1:0] result
);

  localparam int IDX_W = $clog2(CODE_W);
  localparam int SHIFT = CODE_W - LO_W;

  logic [CNT_W-1:0] nbits;
  logic [CNT_W-1:0] span2;
  logic [CNT_W-1:0] off;
  logic [IDX_W-1:0] idx;
  logic             in_trial;

  always_comb begin
    nbits    = hi ? CNT_W'(CODE_W) : CNT_W'(LO_W);
    span2    = nbits << 1;
    off      = cnt - samp_len;
    in_trial = busy && (cnt >= samp_len) && (off < span2);
    idx      = IDX_W'(CODE_W - 1) - IDX_W'(off >> 1);
  end

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      code <= '0;
    end else if (in_trial) begin
      if (!off[0])      code[idx] <= 1'b1;
      else if (!cmp_in) code[idx] <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)        result <= '0;
    else if (store) result <= hi ? code : (code >> SHIFT);
  end

endmodule

// File: rtl/adc_sar_sequencer.sv
module adc_sar_sequencer
  import adc_seq_pkg::*;
#(
  parameter int CH_COUNT = 12,
  parameter int CODE_W   = 10,
  parameter int LO_W     = 8,
  parameter int LEN_LO   = 49,
  parameter int LEN_HI   = 59,
  parameter int LEN_SH_LO = 28,
  parameter int LEN_SH_HI = 33,
  parameter int CH_W     = $clog2(CH_COUNT),
  parameter int CNT_W    = $clog2(LEN_HI + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_set,
  input  logic              start_clr,
  input  logic [CH_W-1:0]   chan_sel,
  input  logic              res10,
  input  logic              repeat_en,
  input  logic              hold_en,
  input  logic              capture_mode,
  input  logic              timer_evt,
  input  logic              cmp_in,
  output logic [CODE_W-1:0] trial_code,
  output logic [CH_W-1:0]   chan_out,
  output logic              sample,
  output logic              busy,
  output logic              start_bit,
  output logic              done,
  output logic [CODE_W-1:0] result
);

  localparam logic [CNT_W-1:0] NB_HI = CNT_W'(CODE_W);
  localparam logic [CNT_W-1:0] NB_LO = CNT_W'(LO_W);

  conv_mode_t       mode_q;
  logic [CH_W-1:0]  chan_q;
  logic [CNT_W-1:0] len_q;
  logic [CNT_W-1:0] samp_q;
  logic [CNT_W-1:0] cnt;
  logic             launch;
  logic             last;
  logic             abort;
  logic             rearm;
  logic             oneshot_end;
  logic             store;
  logic             code_clear;
  conv_phase_e      phase;

  always_comb begin
    abort       = busy & start_clr;
    store       = last & ~start_clr;
    rearm       = store & mode_q.rep;
    oneshot_end = store & ~mode_q.rep;
    code_clear  = launch | abort | last;
  end

  // Span selection by timing style and resolution.
  always_comb begin
    unique case ({mode_q.hold, mode_q.hi})
      2'b00:   len_q = CNT_W'(LEN_LO);
      2'b01:   len_q = CNT_W'(LEN_HI);
      2'b10:   len_q = CNT_W'(LEN_SH_LO);
      default: len_q = CNT_W'(LEN_SH_HI);
    endcase
    samp_q = len_q - ((mode_q.hi ? NB_HI : NB_LO) << 1) - CNT_W'(1);
  end

  // Mode and channel are captured once per launch; repeat restarts reuse them.
  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q <= '0;
      chan_q <= '0;
    end else if (launch) begin
      mode_q <= make_mode(res10, hold_en, repeat_en);
      chan_q <= chan_sel;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) done <= 1'b0;
    else     done <= store;
  end

  adc_seq_trigger u_trigger (
    .clk          (clk),
    .rst          (rst),
    .start_set    (start_set),
    .start_clr    (start_clr),
    .capture_mode (capture_mode),
    .timer_evt    (timer_evt),
    .busy         (busy),
    .oneshot_end  (oneshot_end),
    .start_bit    (start_bit),
    .launch       (launch)
  );

  adc_seq_timer #(.CNT_W(CNT_W)) u_timer (
    .clk      (clk),
    .rst      (rst),
    .launch   (launch),
    .abort    (abort),
    .rearm    (rearm),
    .span     (len_q),
    .samp_len (samp_q),
    .busy     (busy),
    .cnt      (cnt),
    .last     (last),
    .phase    (phase)
  );

  adc_seq_sar #(.CODE_W(CODE_W), .LO_W(LO_W), .CNT_W(CNT_W)) u_sar (
    .clk      (clk),
    .rst      (rst),
    .clear    (code_clear),
    .busy     (busy),
    .hi       (mode_q.hi),
    .cnt      (cnt),
    .samp_len (samp_q),
    .cmp_in   (cmp_in),
    .store    (store),
    .code     (trial_code),
    .result   (result)
  );

  assign chan_out = chan_q;
  assign sample   = (phase == PH_SAMPLE);

endmodule

// File: rtl/adc_sar_sequencer_chk.sv
module adc_sar_sequencer_chk #(
  parameter int CODE_W   = 10,
  parameter int LO_W     = 8,
  parameter int CNT_W    = 6,
  parameter int CH_W     = 4,
  parameter int CH_COUNT = 12
) (
  input logic              clk,
  input logic              rst,
  input logic              busy,
  input logic              done,
  input logic              start_bit,
  input logic              start_clr,
  input logic              sample,
  input logic              launch,
  input logic              hi_q,
  input logic              rep_q,
  input logic [CNT_W-1:0]  len_q,
  input logic [CH_W-1:0]   chan_out,
  input logic [CODE_W-1:0] trial_code,
  input logic [CODE_W-1:0] result
);

  // Busy cycles of the conversion that is ending.
  logic [CNT_W-1:0] cyc;
  always_ff @(posedge clk) begin
    if (rst || launch) cyc <= '0;
    else if (done)     cyc <= busy ? CNT_W'(1) : '0;
    else if (busy)     cyc <= cyc + CNT_W'(1);
  end

  assert_span_R5_R6: assert property (@(posedge clk) disable iff (rst)
    done |-> cyc == len_q);

  assert_done_pulse_R11: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  assert_oneshot_end_R11: assert property (@(posedge clk) disable iff (rst)
    (done && !rep_q) |-> (!start_bit && !busy));

  assert_idle_dac_R11: assert property (@(posedge clk) disable iff (rst)
    !busy |-> trial_code == '0);

  assert_repeat_run_R12: assert property (@(posedge clk) disable iff (rst)
    (done && rep_q) |-> (start_bit && busy));

  assert_repeat_narrow_R12: assert property (@(posedge clk) disable iff (rst)
    (busy && rep_q) |-> !hi_q);

  assert_low_bits_R4: assert property (@(posedge clk) disable iff (rst)
    (busy && !hi_q) |-> trial_code[CODE_W-LO_W-1:0] == '0);

  assert_sample_quiet_R7: assert property (@(posedge clk) disable iff (rst)
    sample |-> (busy && trial_code == '0));

  assert_abort_R13: assert property (@(posedge clk) disable iff (rst)
    (busy && start_clr) |=> (!busy && !done && !start_bit && $stable(result)));

  assert_chan_hold_R1: assert property (@(posedge clk) disable iff (rst)
    (busy && !launch) |=> (!busy || $stable(chan_out)));

  assert_chan_range_R1: assert property (@(posedge clk) disable iff (rst)
    busy |-> chan_out < CH_W'(CH_COUNT));

  assert_narrow_result_R10: assert property (@(posedge clk) disable iff (rst)
    (done && !hi_q) |-> result[CODE_W-1:LO_W] == '0);

endmodule

bind adc_sar_sequencer adc_sar_sequencer_chk #(
  .CODE_W   (CODE_W),
  .LO_W     (LO_W),
  .CNT_W    (CNT_W),
  .CH_W     (CH_W),
  .CH_COUNT (CH_COUNT)
) u_chk (
  .clk        (clk),
  .rst        (rst),
  .busy       (busy),
  .done       (done),
  .start_bit  (start_bit),
  .start_clr  (start_clr),
  .sample     (sample),
  .launch     (launch),
  .hi_q       (mode_q.hi),
  .rep_q      (mode_q.rep),
  .len_q      (len_q),
  .chan_out   (chan_out),
  .trial_code (trial_code),
  .result     (result)
);

// File: tb/adc_sar_sequencer_test.sv
`timescale 1ns/1ps
module adc_sar_sequencer_test;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       start_set = 1'b0, start_clr = 1'b0;
  logic [3:0] chan_sel = '0;
  logic       res10 = 1'b0, repeat_en = 1'b0, hold_en = 1'b0;
  logic       capture_mode = 1'b0, timer_evt = 1'b0;
  logic       cmp_in;
  logic [9:0] trial_code, result;
  logic [3:0] chan_out;
  logic       sample, busy, start_bit, done;
  int         vin = 0;
  int         n_chk = 0, n_fail = 0;

  always #2.5 clk = ~clk;

  // Behavioural comparator: input level against trial level.
  assign cmp_in = (vin >= int'(trial_code));

  adc_sar_sequencer uut (
    .clk(clk), .rst(rst), .start_set(start_set), .start_clr(start_clr),
    .chan_sel(chan_sel), .res10(res10), .repeat_en(repeat_en), .hold_en(hold_en),
    .capture_mode(capture_mode), .timer_evt(timer_evt), .cmp_in(cmp_in),
    .trial_code(trial_code), .chan_out(chan_out), .sample(sample), .busy(busy),
    .start_bit(start_bit), .done(done), .result(result)
  );

  task automatic chk(input bit ok, input string what, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
    end
  endtask

  function automatic int span_of(input bit hi, input bit sh);
    if (sh) return hi ? 33 : 28;
    return hi ? 59 : 49;
  endfunction

  // ---------------- cycle reference model ----------------
  int m_start, m_busy, m_cnt, m_code, m_result, m_done, m_chan;
  int m_hi, m_sh, m_rep;

  always @(posedge clk) begin
    int n, len, s, step, bp;
    if (rst) begin
      m_start <= 0; m_busy <= 0; m_cnt <= 0; m_code <= 0;
      m_result <= 0; m_done <= 0; m_chan <= 0; m_hi <= 0; m_sh <= 0; m_rep <= 0;
    end else begin
      m_done <= 0;
      if (m_busy != 0) begin
        n = m_hi ? 10 : 8;
        len = span_of(m_hi != 0, m_sh != 0);
        s = len - 2 * n - 1;
        step = m_cnt - s;
        if (start_clr) begin
          m_busy <= 0; m_start <= 0; m_code <= 0; m_cnt <= 0;
        end else if (m_cnt == len - 1) begin
          m_result <= m_hi ? m_code : (m_code >> 2);
          m_done <= 1; m_code <= 0; m_cnt <= 0;
          if (m_rep == 0) begin m_busy <= 0; m_start <= 0; end
        end else begin
          m_cnt <= m_cnt + 1;
          if (step >= 0 && step < 2 * n) begin
            bp = 9 - step / 2;
            if (step % 2 == 0) m_code <= m_code | (1 << bp);
            else if (!(vin >= m_code)) m_code <= m_code & ~(1 << bp);
          end
        end
      end else begin
        if (start_clr) m_start <= 0;
        else if (start_set) m_start <= 1;
        if (!start_clr && m_start != 0 && (!capture_mode || timer_evt)) begin
          m_busy <= 1; m_cnt <= 0; m_code <= 0; m_chan <= int'(chan_sel);
          m_hi <= (res10 && !repeat_en) ? 1 : 0;
          m_sh <= hold_en ? 1 : 0; m_rep <= repeat_en ? 1 : 0;
        end
      end
    end
  end

  always @(negedge clk) begin
    int s;
    if (!rst) begin
      s = span_of(m_hi != 0, m_sh != 0) - 2 * (m_hi ? 10 : 8) - 1;
      chk(int'(busy) == (m_busy != 0 ? 1 : 0), "R5 model busy", int'(busy), m_busy);
      chk(int'(start_bit) == (m_start != 0 ? 1 : 0), "R2 model start_bit", int'(start_bit), m_start);
      chk(int'(done) == m_done, "R11 model done", int'(done), m_done);
      chk(int'(trial_code) == m_code, "R8 model trial_code", int'(trial_code), m_code);
      chk(int'(result) == m_result, "R10 model result", int'(result), m_result);
      chk(int'(chan_out) == m_chan, "R1 model chan_out", int'(chan_out), m_chan);
      chk(int'(sample) == ((m_busy != 0 && m_cnt < s) ? 1 : 0), "R7 model sample",
          int'(sample), (m_busy != 0 && m_cnt < s) ? 1 : 0);
    end
  end

  // ---------------- directed stimulus ----------------
  task automatic tick(input int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_start();
    start_set = 1'b1; tick(); start_set = 1'b0;
  endtask

  task automatic run_one(input int ch, input bit hi, input bit sh, input int v);
    int nb, busy_c, samp_c, guard, expv, low_bad;
    nb = hi ? 10 : 8;
    chan_sel = 4'(ch); res10 = hi; hold_en = sh; repeat_en = 1'b0; vin = v;
    busy_c = 0; samp_c = 0; guard = 0; low_bad = 0;
    pulse_start();
    while (!done && guard < 200) begin
      tick(); guard++;
      if (busy) busy_c++;
      if (sample) samp_c++;
      if (busy && !hi && trial_code[1:0] != 2'b00) low_bad++;
      if (busy && int'(chan_out) != ch) low_bad += 100;
    end
    expv = hi ? ((v > 1023) ? 1023 : v) : (((v > 1023) ? 1023 : v) >> 2);
    chk(busy_c == span_of(hi, sh), sh ? "R6 span" : "R5 span", busy_c, span_of(hi, sh));
    chk(samp_c == span_of(hi, sh) - 2 * nb - 1, "R7 sample window", samp_c,
        span_of(hi, sh) - 2 * nb - 1);
    chk(int'(result) == expv, "R8 R10 result", int'(result), expv);
    chk(low_bad == 0, "R4 R1 low bits and channel hold", low_bad, 0);
    chk(!start_bit && !busy && trial_code == 0, "R11 end state",
        {start_bit, busy, trial_code != 0}, 0);
    tick();
    chk(!done, "R11 done single cycle", int'(done), 0);
  endtask

  initial begin
    int prev, gap, guard, seen;
    tick(3); rst = 1'b0; tick();
    chk(!busy && !start_bit && result == 0 && !done, "R10 reset state",
        {busy, start_bit, done}, 0);

    // R3: a timer event with the start bit clear does nothing
    capture_mode = 1'b1; timer_evt = 1'b1; tick(); timer_evt = 1'b0; tick();
    chk(!busy, "R3 event without start bit", int'(busy), 0);
    capture_mode = 1'b0;

    run_one(3, 1'b1, 1'b0, 'h2A5);
    run_one(11, 1'b0, 1'b0, 'h2A5);
    run_one(0, 1'b1, 1'b1, 'h155);
    run_one(7, 1'b0, 1'b1, 'h0FF);
    run_one(2, 1'b1, 1'b0, 0);
    run_one(5, 1'b1, 1'b1, 2000);   // R9 full scale 10-bit
    chk(result == 10'h3FF, "R9 full scale 10-bit", int'(result), 'h3FF);
    run_one(5, 1'b0, 1'b0, 2000);   // R9 full scale 8-bit
    chk(result == 10'h0FF, "R9 full scale 8-bit", int'(result), 'h0FF);

    // R3: capture trigger waits for the timer event
    capture_mode = 1'b1; chan_sel = 4'd4; res10 = 1'b1; hold_en = 1'b1; vin = 'h0AB;
    pulse_start(); tick(8);
    chk(!busy && start_bit, "R3 waits for event", int'(busy), 0);
    timer_evt = 1'b1; tick(); timer_evt = 1'b0;
    chk(busy, "R3 event launches", int'(busy), 1);
    guard = 0;
    while (!done && guard < 200) begin tick(); guard++; end
    chk(result == 10'h0AB, "R3 capture result", int'(result), 'h0AB);
    capture_mode = 1'b0; tick(2);

    // R12: repeat mode, forced 8-bit, back to back on one channel
    chan_sel = 4'd9; res10 = 1'b1; hold_en = 1'b0; repeat_en = 1'b1; vin = 'h300;
    pulse_start();
    guard = 0;
    while (!done && guard < 200) begin tick(); guard++; end
    chk(result == 10'h0C0, "R12 repeat forced 8-bit result", int'(result), 'h0C0);
    chk(start_bit && busy, "R12 start bit held", {start_bit, busy}, 3);
    vin = 'h100; chan_sel = 4'd1;
    gap = 0;
    do begin tick(); gap++; end while (!done && gap < 200);
    chk(gap == 49, "R12 back-to-back spacing", gap, 49);
    chk(result == 10'h040, "R12 second result", int'(result), 'h040);
    chk(chan_out == 4'd9, "R1 R12 same channel", int'(chan_out), 9);
    tick(5);
    prev = int'(result);
    start_clr = 1'b1; tick(); start_clr = 1'b0;
    chk(!busy && !start_bit && int'(result) == prev, "R13 stop repeat",
        {busy, start_bit}, 0);
    repeat_en = 1'b0; tick(2);

    // R13: abort a one-shot conversion mid-way
    chan_sel = 4'd6; res10 = 1'b1; vin = 'h123;
    pulse_start(); tick(45);
    prev = int'(result);
    start_clr = 1'b1; tick(); start_clr = 1'b0;
    chk(!busy && !start_bit && trial_code == 0, "R13 abort to idle",
        {busy, start_bit}, 0);
    seen = 0;
    for (int i = 0; i < 70; i++) begin tick(); if (done) seen++; end
    chk(seen == 0 && int'(result) == prev, "R13 no done and result kept", seen, 0);

    // R2: normal launch after an abort
    run_one(10, 1'b1, 1'b0, 'h3A1);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired: run did not finish");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule